// File: doc/BRIEF.md
# Moving Message Sequencer

This block produces the letter-enable outputs of a moving message sign. A serial chain of flip-flops, built from cascaded fixed-width segments, lights one letter after another. A programmable divider sets the step rate. It issues a one-cycle step enable from the system clock, so the design runs on a single clock.

Two animations are available. In fill-and-clear, the chain takes in a 1 on every step until the last letter is lit. It then holds that fully lit pattern for one step, and the next step blanks every letter at once. In fill-and-drain, the serial input is the inverse of the last letter. The sign therefore fills from the first letter, then empties from the first letter in the same direction, and then fills again. A request to change the animation is applied only while every letter is dark. A run that is already in progress finishes in the animation it started with.

Top module: `msg_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets every letter output to 0 and restarts the step divider at count 0.
- R2: With divider value D held constant after reset, a step occurs on every (D+1)-th clock edge. A step is taken whenever the internal count is greater than or equal to D, and the count then returns to 0. Between steps the letter outputs do not change.
- R3: On a step, if the last letter (bit N_LETTERS-1) is 0, each letter k>0 takes the previous value of letter k-1. Letter 0 (bit 0) is the entry point of the chain.
- R4: In fill-and-clear mode (`mode_i` = 0), a step with the last letter at 0 loads a 1 into letter 0.
- R5: In fill-and-clear mode, a step taken while the last letter is 1 clears all letters at once. The fully lit pattern is therefore visible for one whole step period.
- R6: In fill-and-drain mode (`mode_i` = 1), every step loads the inverse of the previous last letter into letter 0 and shifts the rest. Once the sign is full, letters go dark starting at letter 0.
- R7: In fill-and-drain mode, the sequence from all dark repeats every 2*N_LETTERS steps, with filling restarting at letter 0.
- R8: The mode in effect is taken from `mode_i` only while all letters are 0. While any letter is lit, changes on `mode_i` do not alter the running animation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | Animation request: 0 fill-and-clear, 1 fill-and-drain |
| rate_div_i | input | DIV_W | Step divider value D; step period is D+1 clocks |
| letters_o | output | N_LETTERS | Letter enables, bit 0 lights first |

## Verification
The assertions assume that `rst` is held for at least one edge before the first check that matters. They also assume that `mode_i` and `rate_div_i` are stable from one clock edge to the next. The step relations are stated per step, so a change of divider value in mid-count is allowed. The stimulus drives all inputs on the falling clock edge. It keeps the divider small (0 to 3) so that many full fill, clear and drain cycles happen, and it toggles the mode request at random points, both while the sign is lit and while it is dark. Occasional resets land at arbitrary phases of the pattern.

// File: rtl/msg_seq_pkg.sv
package msg_seq_pkg;

    typedef enum logic {
        MODE_FILL_CLEAR = 1'b0,
        MODE_FILL_DRAIN = 1'b1
    } seq_mode_e;

endpackage

// File: rtl/msg_rate_div.sv
module msg_rate_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] rate_div_i,
    output logic             step_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        hit  = (st_q.cnt >= rate_div_i);
        if (hit) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rst) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign step_o = hit && !rst;

endmodule

// File: rtl/msg_shift_seg.sv
module msg_shift_seg #(
    parameter int SEG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             clear_i,
    input  logic             sin_i,
    output logic [SEG_W-1:0] q_o
);

    typedef struct packed {
        logic [SEG_W-1:0] bits;
    } seg_state_t;

    seg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bits = '0;
        end else if (step_i) begin
            if (clear_i) begin
                st_d.bits = '0;
            end else begin
                st_d.bits = {st_q.bits[SEG_W-2:0], sin_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_o = st_q.bits;

endmodule

// File: rtl/msg_mode_ctrl.sv
module msg_mode_ctrl
    import msg_seq_pkg::*;
#(
    parameter int N_LETTERS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_i,
    input  logic [N_LETTERS-1:0] letters_i,
    output logic                 serial_o,
    output logic                 clear_o,
    output logic                 eff_mode_o
);

    typedef struct packed {
        seq_mode_e mode;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    seq_mode_e   eff;
    logic        dark;
    logic        last;

    always_comb begin
        dark = (letters_i == '0);
        last = letters_i[N_LETTERS-1];
        eff  = dark ? seq_mode_e'(mode_i) : st_q.mode;
        st_d = st_q;
        st_d.mode = eff;
        if (rst) begin
            st_d.mode = MODE_FILL_CLEAR;
        end
        serial_o = (eff == MODE_FILL_DRAIN) ? ~last : 1'b1;
        clear_o  = (eff == MODE_FILL_CLEAR) && last;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign eff_mode_o = eff;

endmodule

// File: rtl/msg_sequencer.sv
module msg_sequencer #(
    parameter int N_LETTERS = 16,
    parameter int SEG_W     = 8,
    parameter int DIV_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_i,
    input  logic [DIV_W-1:0]     rate_div_i,
    output logic [N_LETTERS-1:0] letters_o
);

    localparam int N_SEG = N_LETTERS / SEG_W;

    logic             step_w;
    logic             serial_w;
    logic             clear_w;
    logic             eff_mode_w;
    logic [SEG_W-1:0] seg_q [N_SEG];
    logic             seg_sin [N_SEG];

    msg_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .rate_div_i (rate_div_i),
        .step_o     (step_w)
    );

    msg_mode_ctrl #(.N_LETTERS(N_LETTERS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_i),
        .letters_i  (letters_o),
        .serial_o   (serial_w),
        .clear_o    (clear_w),
        .eff_mode_o (eff_mode_w)
    );

    for (genvar g = 0; g < N_SEG; g++) begin : g_seg
        if (g == 0) begin : g_head
            assign seg_sin[g] = serial_w;
        end else begin : g_link
            assign seg_sin[g] = seg_q[g-1][SEG_W-1];
        end

        msg_shift_seg #(.SEG_W(SEG_W)) u_seg (
            .clk     (clk),
            .rst     (rst),
            .step_i  (step_w),
            .clear_i (clear_w),
            .sin_i   (seg_sin[g]),
            .q_o     (seg_q[g])
        );

        assign letters_o[g*SEG_W +: SEG_W] = seg_q[g];
    end

endmodule

// File: rtl/msg_seq_checker.sv
module msg_seq_checker #(
    parameter int N_LETTERS = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N_LETTERS-1:0] letters,
    input logic                 step,
    input logic                 eff_mode
);

    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    always @(negedge clk) begin
        if (rst_q) begin
            assert_reset_clear_R1: assert (letters == '0);
        end
    end

    assert_hold_between_steps_R2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(letters));

    assert_shift_order_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !letters[N_LETTERS-1]) |=> letters[N_LETTERS-1:1] == $past(letters[N_LETTERS-2:0]));

    assert_fill_one_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !letters[N_LETTERS-1] && eff_mode == 1'b0) |=> letters[0]);

    assert_full_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (step && letters[N_LETTERS-1] && eff_mode == 1'b0) |=> letters == '0);

    assert_drain_feedback_R6: assert property (@(posedge clk) disable iff (rst)
        (step && eff_mode == 1'b1) |=> letters[0] == !$past(letters[N_LETTERS-1]));

    assert_mode_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (letters != '0 && !step) |=> eff_mode == $past(eff_mode));

endmodule

bind msg_sequencer msg_seq_checker #(.N_LETTERS(N_LETTERS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .letters  (letters_o),
    .step     (step_w),
    .eff_mode (eff_mode_w)
);

// File: tb/msg_sequencer_tb.sv
module msg_sequencer_tb;

    localparam int N     = 16;
    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic [N-1:0]     letters;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;

    logic [DIV_W-1:0] m_cnt = '0;
    logic [N-1:0]     m_pat = '0;
    logic             m_amode = 1'b0;

    always #10 clk = ~clk;

    msg_sequencer u_dut (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .rate_div_i (div),
        .letters_o  (letters)
    );

    function automatic logic [N-1:0] next_pat(logic [N-1:0] p, logic md);
        if (md) return {p[N-2:0], ~p[N-1]};
        if (p[N-1]) return '0;
        return {p[N-2:0], 1'b1};
    endfunction

    task automatic check(string tag);
        n_checks++;
        if (letters !== m_pat) begin
            n_err++;
            $display("FAIL %s cycle %0d letters=%h expected=%h", tag, cyc, letters, m_pat);
        end
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) begin
            logic [DIV_W-1:0] c_n;
            logic [N-1:0]     p_n;
            logic             a_n;
            logic             em;
            em = (m_pat == '0) ? mode : m_amode;
            if (rst) begin
                c_n = '0; p_n = '0; a_n = 1'b0;
            end else if (m_cnt >= div) begin
                c_n = '0; p_n = next_pat(m_pat, em); a_n = em;
            end else begin
                c_n = m_cnt + 1'b1; p_n = m_pat; a_n = em;
            end
            @(posedge clk);
            @(negedge clk);
            cyc++;
            m_cnt = c_n; m_pat = p_n; m_amode = a_n;
            check(tag);
        end
    endtask

    initial begin
        for (int w = 0; w < 150000; w++) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h0005eed1));
        @(negedge clk);
        rst = 1'b1; mode = 1'b0; div = 16'd2;
        run(3, "R1 reset state");

        // fill-and-clear, step every 3 clocks: fill, full hold, clear
        rst = 1'b0;
        run(3 * (2 * (N + 1)) + 5, "R2 R3 R4 R5 fill-clear");

        // reset in mid-pattern
        rst = 1'b1;
        run(1, "R1 mid-run reset");
        rst = 1'b0;

        // fill-and-drain at full rate, two whole periods
        mode = 1'b1; div = '0;
        run(4 * N + 3, "R6 R7 fill-drain");

        // mode request changed while lit: drain must continue
        rst = 1'b1; run(1, "R1"); rst = 1'b0;
        mode = 1'b1; div = '0;
        run(5, "R8 partial fill");
        mode = 1'b0;
        run(2 * N + 4, "R8 mode held while lit");

        // mode request changed while lit in fill-and-clear
        rst = 1'b1; run(1, "R1"); rst = 1'b0;
        mode = 1'b0; div = 16'd1;
        run(6, "R8 partial fill");
        mode = 1'b1;
        run(2 * (N + 2), "R8 clear still applies");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 49) == 0) div = 16'($urandom_range(0, 3));
            if ($urandom_range(0, 39) == 0) mode = ~mode;
            rst = ($urandom_range(0, 499) == 0);
            run(1, "R2 R3 R4 R5 R6 R7 R8 random");
        end
        rst = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule